// File: doc/BRIEF.md
# Neuro-Core Time-Step Sequencer

This block sequences one time step of a spiking neuron core. It is a seven-state controller. While idle it waits for a start pulse. It then pulls address events from an input event queue into the crossbar (DOWNLOAD). Next it lets the crossbar and neuron array fetch and accumulate the synaptic weights of every event it pulled (COMP). After that it runs the membrane leak (LEAK), the threshold test (FIRE) and the transfer of output spikes to the network (UPLOAD). When learning is enabled, it also runs the plasticity unit (LEARN).

Each phase is shown to the datapath as one bit of a one-hot phase vector. The phase is held until the datapath reports that the phase is finished. When the step is complete, a single-cycle `step_done` pulse marks it. The arithmetic, the memories and the packet routing all sit outside the block.

The states are IDLE, DOWNLOAD, COMP, LEAK, FIRE, UPLOAD and LEARN. The transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | DOWNLOAD | `start_step` |
| DOWNLOAD | COMP | `fifo_empty` |
| COMP | LEAK | processed event count equals downloaded event count |
| LEAK | FIRE | `leak_done` |
| FIRE | UPLOAD | `fire_done` |
| UPLOAD | LEARN | `upload_done` and `learn_en` high |
| UPLOAD | IDLE | `upload_done` and `learn_en` low |
| LEARN | IDLE | `learn_done` |

Top module: `nc_step_sequencer`

## Requirements
- R1: After reset the block is in IDLE: `phase_vec` equals 7'b0000001, and `ev_pop` and `step_done` are low.
- R2: IDLE is left only on a cycle with `start_step` high, and the next phase is DOWNLOAD. `start_step` has no effect in any other phase.
- R3: In DOWNLOAD, `ev_pop` is high on every cycle in which `fifo_empty` is low, and each such cycle counts one event. The first cycle that sees `fifo_empty` high moves to COMP. With n queued events, DOWNLOAD therefore lasts n+1 cycles and issues exactly n pops.
- R4: COMP is held until the number of `comp_ev_done` pulses accepted in COMP equals the number of events popped in this step, so it takes at least one cycle. `comp_ev_done` pulses outside COMP, or beyond that number, are ignored. The counts are cleared when a step starts.
- R5: LEAK, FIRE and UPLOAD each last until their own done input (`leak_done`, `fire_done`, `upload_done`) is seen high. A done input seen in any other phase has no effect.
- R6: On leaving UPLOAD the block enters LEARN only if `learn_en` is high, and it holds LEARN until `learn_done` is high. With `learn_en` low it goes straight to IDLE.
- R7: `step_done` is high for exactly one cycle: the first IDLE cycle after UPLOAD (learning off) or after LEARN. It is low at all other times.
- R8: `phase_vec` is one-hot at all times. The bit positions are: bit 0 IDLE, bit 1 DOWNLOAD, bit 2 COMP, bit 3 LEAK, bit 4 FIRE, bit 5 UPLOAD, bit 6 LEARN.
- R9: Within a step, the phases always follow the order DOWNLOAD, COMP, LEAK, FIRE, UPLOAD, then optionally LEARN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_step | input | 1 | Starts a time step when seen in IDLE |
| learn_en | input | 1 | Enables the LEARN phase, sampled on leaving UPLOAD |
| fifo_empty | input | 1 | Input event queue holds no event |
| ev_pop | output | 1 | Takes one event from the queue into the crossbar |
| comp_ev_done | input | 1 | Crossbar/neuron array finished one event |
| leak_done | input | 1 | Leak stage finished |
| fire_done | input | 1 | Threshold stage finished |
| upload_done | input | 1 | Output spike transfer finished |
| learn_done | input | 1 | Plasticity unit finished |
| phase_vec | output | 7 | One-hot current phase |
| step_done | output | 1 | One-cycle end-of-step pulse |

## Verification
The assertions rely on two assumptions. First, the event queue never delivers more events in one step than the event counter can hold. Second, the datapath raises `comp_ev_done` only for events that have already been popped. The bench keeps to both: it loads at most four events per step, and its crossbar model pulses only while it still owes completions. The sweep covers event count, completion gap, done latency, the learning enable, and a noise mode. In noise mode every done line and `start_step` are raised outside their own phase, so their lack of effect shows up in the measured phase lengths.

// File: rtl/nc_seq_pkg.sv
package nc_seq_pkg;

    localparam int NUM_PHASES = 7;
    localparam int PH_W       = $clog2(NUM_PHASES);

    // Phase encodings double as bit positions in the one-hot phase vector.
    typedef enum logic [PH_W-1:0] {
        PH_IDLE     = 3'd0,
        PH_DOWNLOAD = 3'd1,
        PH_COMP     = 3'd2,
        PH_LEAK     = 3'd3,
        PH_FIRE     = 3'd4,
        PH_UPLOAD   = 3'd5,
        PH_LEARN    = 3'd6
    } phase_e;

endpackage

// File: rtl/nc_event_tally.sv
module nc_event_tally
    import nc_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_begin,
    input  logic in_download,
    input  logic in_comp,
    input  logic fifo_empty,
    input  logic comp_ev_done,
    output logic ev_pop,
    output logic all_processed
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] taken_cnt;
    logic [CNT_W-1:0] served_cnt;
    logic             accept_done;

    always_comb begin
        ev_pop        = in_download & ~fifo_empty;
        all_processed = (served_cnt == taken_cnt);
        accept_done   = in_comp & comp_ev_done & ~all_processed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_cnt  <= '0;
            served_cnt <= '0;
        end else if (step_begin) begin
            taken_cnt  <= '0;
            served_cnt <= '0;
        end else begin
            if (ev_pop)      taken_cnt  <= taken_cnt + 1'b1;
            if (accept_done) served_cnt <= served_cnt + 1'b1;
        end
    end

    // R4: completions never run ahead of downloads
    a_r4_served_le_taken: assert property (@(posedge clk) disable iff (!rst_n)
        served_cnt <= taken_cnt);

    // R3: the event count must not wrap within one step
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pop |-> (taken_cnt != CNT_MAX));

    // R4: an accepted completion moves the served count on by one
    a_r4_served_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_done && !step_begin) |=> (served_cnt == $past(served_cnt) + 1'b1));

endmodule

// File: rtl/nc_phase_fsm.sv
module nc_phase_fsm
    import nc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_step,
    input  logic   learn_en,
    input  logic   fifo_empty,
    input  logic   all_processed,
    input  logic   leak_done,
    input  logic   fire_done,
    input  logic   upload_done,
    input  logic   learn_done,
    output phase_e state,
    output logic   step_begin,
    output logic   step_done
);

    phase_e state_nx;
    logic   finishing;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:     if (start_step)    state_nx = PH_DOWNLOAD;
            PH_DOWNLOAD: if (fifo_empty)    state_nx = PH_COMP;
            PH_COMP:     if (all_processed) state_nx = PH_LEAK;
            PH_LEAK:     if (leak_done)     state_nx = PH_FIRE;
            PH_FIRE:     if (fire_done)     state_nx = PH_UPLOAD;
            PH_UPLOAD:   if (upload_done)   state_nx = learn_en ? PH_LEARN : PH_IDLE;
            PH_LEARN:    if (learn_done)    state_nx = PH_IDLE;
            default:                        state_nx = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        step_begin = (state == PH_IDLE) && start_step;
        finishing  = ((state == PH_UPLOAD) && upload_done && !learn_en) ||
                     ((state == PH_LEARN) && learn_done);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) step_done <= 1'b0;
        else        step_done <= finishing;
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && !start_step) |=> (state == PH_IDLE));

    a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && start_step) |=> (state == PH_DOWNLOAD));

    a_r5_leak_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LEAK && !leak_done) |=> (state == PH_LEAK));

    a_r5_fire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_FIRE && !fire_done) |=> (state == PH_FIRE));

    a_r6_skip_learn: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_UPLOAD && upload_done && !learn_en) |=> (state == PH_IDLE));

    a_r6_learn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LEARN && !learn_done) |=> (state == PH_LEARN));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    a_r7_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (state == PH_IDLE));

    a_r9_after_comp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LEAK && $past(state) != PH_LEAK) |-> ($past(state) == PH_COMP));

endmodule

// File: rtl/nc_phase_decode.sv
module nc_phase_decode
    import nc_seq_pkg::*;
(
    input  phase_e                  state,
    output logic [NUM_PHASES-1:0]   phase_vec
);

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_bit
        assign phase_vec[i] = (state == PH_W'(i));
    end

    // R8: exactly one phase is shown at any time
    always_comb begin
        a_r8_onehot: assert ($countones(phase_vec) == 1);
    end

endmodule

// File: rtl/nc_step_sequencer.sv
module nc_step_sequencer
    import nc_seq_pkg::*;
#(
    parameter int EV_CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_step,
    input  logic                  learn_en,
    input  logic                  fifo_empty,
    output logic                  ev_pop,
    input  logic                  comp_ev_done,
    input  logic                  leak_done,
    input  logic                  fire_done,
    input  logic                  upload_done,
    input  logic                  learn_done,
    output logic [NUM_PHASES-1:0] phase_vec,
    output logic                  step_done
);

    phase_e state;
    logic   step_begin;
    logic   all_processed;

    nc_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_step   (start_step),
        .learn_en     (learn_en),
        .fifo_empty   (fifo_empty),
        .all_processed(all_processed),
        .leak_done    (leak_done),
        .fire_done    (fire_done),
        .upload_done  (upload_done),
        .learn_done   (learn_done),
        .state        (state),
        .step_begin   (step_begin),
        .step_done    (step_done)
    );

    nc_event_tally #(.CNT_W(EV_CNT_W)) u_tally (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_begin   (step_begin),
        .in_download  (phase_vec[PH_DOWNLOAD]),
        .in_comp      (phase_vec[PH_COMP]),
        .fifo_empty   (fifo_empty),
        .comp_ev_done (comp_ev_done),
        .ev_pop       (ev_pop),
        .all_processed(all_processed)
    );

    nc_phase_decode u_decode (
        .state    (state),
        .phase_vec(phase_vec)
    );

    // R3: pops happen only while downloading from a non-empty queue
    a_r3_pop_window: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pop |-> (phase_vec[PH_DOWNLOAD] && !fifo_empty));

    // R4: COMP never ends while events are still owed
    a_r4_comp_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vec[PH_COMP] && !all_processed) |=> phase_vec[PH_COMP]);

endmodule

// File: tb/nc_step_sequencer_tb.sv
module nc_step_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_step = 1'b0;
    logic       learn_en = 1'b0;
    logic       fifo_empty;
    logic       ev_pop;
    logic       comp_ev_done = 1'b0;
    logic       leak_done = 1'b0;
    logic       fire_done = 1'b0;
    logic       upload_done = 1'b0;
    logic       learn_done = 1'b0;
    logic [6:0] phase_vec;
    logic       step_done;

    always #2 clk = ~clk;   // 250 MHz

    nc_step_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .start_step(start_step), .learn_en(learn_en),
        .fifo_empty(fifo_empty), .ev_pop(ev_pop), .comp_ev_done(comp_ev_done),
        .leak_done(leak_done), .fire_done(fire_done), .upload_done(upload_done),
        .learn_done(learn_done), .phase_vec(phase_vec), .step_done(step_done)
    );

    int checks = 0;
    int fails  = 0;

    // configuration of the current step (written only by the stimulus block)
    int cfg_n = 0, cfg_g = 0, cfg_d = 0, cfg_noise = 0;
    logic load_req = 1'b0;

    // event queue model
    int fifo_cnt = 0;
    int step_pops = 0;
    assign fifo_empty = (fifo_cnt == 0);
    always @(posedge clk) begin
        if (load_req) begin
            fifo_cnt  <= cfg_n;
            step_pops <= 0;
        end else if (ev_pop) begin
            fifo_cnt  <= fifo_cnt - 1;
            step_pops <= step_pops + 1;
        end
    end

    // phase monitor and datapath responders
    int dur [0:6];
    int prev_ph = 0;
    int k = 0;
    int sent = 0;
    int gap = 0;
    int sd_total = 0;

    function automatic int ph_index(logic [6:0] v);
        int r = -1;
        for (int i = 0; i < 7; i++) if (v[i]) r = i;
        return r;
    endfunction

    always @(negedge clk) begin
        int cur;
        cur = ph_index(phase_vec);
        if (rst_n && cur >= 0) begin
            if (cur != prev_ph) begin
                k = 0;
                if (cur == 1) for (int i = 0; i < 7; i++) dur[i] = 0;
                if (cur == 2) begin sent = 0; gap = 0; end
            end else begin
                k = k + 1;
            end
            dur[cur] = dur[cur] + 1;
            prev_ph = cur;
            if (step_done) sd_total = sd_total + 1;
            // completion model for COMP
            if (cur == 2) begin
                if ((step_pops - sent) > 0 && gap >= cfg_g) begin
                    comp_ev_done <= 1'b1; sent = sent + 1; gap = 0;
                end else begin
                    comp_ev_done <= (cfg_noise != 0) && ((step_pops - sent) == 0);
                    gap = gap + 1;
                end
            end else begin
                comp_ev_done <= (cfg_noise != 0);
            end
            leak_done   <= (cur == 3) ? (k >= cfg_d) : (cfg_noise != 0);
            fire_done   <= (cur == 4) ? (k >= cfg_d) : (cfg_noise != 0);
            upload_done <= (cur == 5) ? (k >= cfg_d) : (cfg_noise != 0);
            learn_done  <= (cur == 6) ? (k >= cfg_d) : (cfg_noise != 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // watchdog
    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run_step(input int n, input int g, input int d, input int lrn, input int noise);
        int waited;
        int sd_before;
        cfg_n = n; cfg_g = g; cfg_d = d; cfg_noise = noise;
        learn_en = lrn[0];
        load_req = 1'b1;
        @(negedge clk);
        load_req  = 1'b0;
        start_step = 1'b1;
        sd_before = sd_total;
        @(negedge clk);
        start_step = 1'b0;
        if (noise != 0) begin
            @(negedge clk);
            @(negedge clk);
            start_step = 1'b1;     // R2: ignored outside IDLE
            @(negedge clk);
            start_step = 1'b0;
        end
        waited = 0;
        while (!step_done && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(phase_vec == 7'b0000001, "R7 step_done in IDLE", phase_vec, 1);
        check(dur[1] == n + 1, "R3 download length", dur[1], n + 1);
        check(step_pops == n, "R3 pop count", step_pops, n);
        check(dur[2] == n * (g + 1) + 1, "R4 comp length", dur[2], n * (g + 1) + 1);
        check(dur[3] == d + 1, "R5 leak length", dur[3], d + 1);
        check(dur[4] == d + 1, "R5 fire length", dur[4], d + 1);
        check(dur[5] == d + 1, "R5 upload length", dur[5], d + 1);
        check(dur[6] == ((lrn != 0) ? d + 1 : 0), "R6 learn length", dur[6], (lrn != 0) ? d + 1 : 0);
        check(dur[0] == 0, "R9 no idle inside step", dur[0], 0);
        @(negedge clk);
        check(!step_done, "R7 pulse width", step_done, 0);
        check(sd_total == sd_before + 1, "R7 pulse count", sd_total - sd_before, 1);
        check(phase_vec == 7'b0000001, "R2 stays idle", phase_vec, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(phase_vec == 7'b0000001, "R1 phase in reset", phase_vec, 1);
        check(!ev_pop && !step_done, "R1 outputs in reset", {ev_pop, step_done}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(phase_vec == 7'b0000001, "R1 R2 idle without start", phase_vec, 1);
            check(!step_done && !ev_pop, "R1 quiet idle", {ev_pop, step_done}, 0);
        end
        for (int n = 0; n <= 4; n++)
            for (int g = 0; g <= 1; g++)
                for (int d = 0; d <= 2; d++)
                    for (int l = 0; l <= 1; l++)
                        for (int z = 0; z <= 1; z++)
                            run_step(n, g, d, l, z);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // R8: one-hot at every sample
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if ($countones(phase_vec) != 1) begin
                fails++;
                $display("FAIL R8 onehot actual=%0d expected=%0d", $countones(phase_vec), 1);
            end
        end
    end

endmodule